// File: doc/BRIEF.md
# Digital Trimmer Wiper Controller

This block is the control side of a 32-position digital trimmer, written as synchronous logic on a system clock. A host drives three asynchronous lines: an active-low select, a step strobe and a direction level. While the trimmer is selected, each falling edge of the step strobe moves a wiper counter by one position, either up or down. The counter saturates at both ends. Its value drives a registered one-hot tap-select bus. An analog switch array outside this block would use that bus.

A shadow register stands in for the non-volatile cell. When the select line is released, the level of the step line at that moment decides what happens. If the step line is high, the wiper position is copied into the shadow register and a busy interval of programmable length follows. If it is low, the trimmer simply deselects and keeps its position. A single-cycle recall input reloads the counter from the shadow register, the way a power-up restore would. A standby flag shows when the trimmer is idle and not selected.

Top module: `trim_wiper`

## Requirements
- R1: While the synchronized select line is high (deselected), step edges do not move the wiper.
- R2: While selected and not busy, each falling edge of the step line moves the wiper by one position: up when the direction line is 1, down when it is 0. The direction may change between steps within one selection.
- R3: The wiper saturates: a step up at position TAPS-1 stays at TAPS-1, and a step down at position 0 stays at 0. The position never wraps.
- R4: `tap_sel` has exactly one bit set, and bit k is set one clock after `wiper_pos` equals k.
- R5: A rising edge of the select line while the step line is high copies `wiper_pos` into `stored_pos`. `stored_pos` changes at no other time except reset.
- R6: A rising edge of the select line while the step line is low leaves `stored_pos` unchanged and keeps the wiper where it is.
- R7: A one-cycle `recall` pulse loads `wiper_pos` with `stored_pos` at the next clock edge. Recall takes priority over stepping.
- R8: Synchronous reset sets `wiper_pos` and `stored_pos` to 0, `tap_sel` to bit 0 only, `busy` to 0 and `standby` to 1.
- R9: A store raises `busy` for exactly BUSY_CYCLES clock cycles. `standby` is 1 exactly when the trimmer is neither busy nor selected, and is never 1 together with `busy`.
- R10: While `busy` is 1, step edges and select edges are ignored: the wiper does not move and no new store starts.
- R11: Each input passes through a two-flop synchronizer. A falling step edge changes `wiper_pos` at the third rising clock edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n_in | input | 1 | Asynchronous select, active low |
| step_in | input | 1 | Asynchronous step strobe, acts on its falling edge |
| dir_in | input | 1 | Asynchronous direction, 1 = up, 0 = down |
| recall | input | 1 | Synchronous pulse that reloads the wiper from the shadow register |
| wiper_pos | output | 5 | Current wiper position (POS_W bits) |
| stored_pos | output | 5 | Shadow (non-volatile model) position (POS_W bits) |
| tap_sel | output | 32 | Registered one-hot tap enable (TAPS bits) |
| busy | output | 1 | Store in progress |
| standby | output | 1 | Idle and deselected |

## Verification
The hardest case to reach is a selection and a step that arrive while a store is still busy. The bench releases the select line with the step line high, which starts a store. It then reselects and strobes the step line inside the busy window, timed against the known synchronizer latency. After the window it checks that neither the wiper nor the shadow value moved, and that stepping works again once busy clears. Saturation is reached by sweeping more steps than there are taps in each direction, and every intermediate position and tap bit is checked.

// File: rtl/trim_pkg.sv
package trim_pkg;
  // next wiper position with saturation at 0 and top
  function automatic int unsigned sat_next(int unsigned cur, logic up, int unsigned top);
    if (up) return (cur >= top) ? top : cur + 1;
    else    return (cur == 0)   ? 0   : cur - 1;
  endfunction
endpackage

// File: rtl/trim_sync.sv
module trim_sync #(
  parameter int         W    = 3,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] lvl_d
);
  logic [W-1:0] meta;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        meta[i]  <= IDLE[i];
        lvl[i]   <= IDLE[i];
        lvl_d[i] <= IDLE[i];
      end else begin
        meta[i]  <= async_in[i];
        lvl[i]   <= meta[i];
        lvl_d[i] <= lvl[i];
      end
    end
  end
endmodule

// File: rtl/trim_counter.sv
module trim_counter #(
  parameter int TAPS  = 32,
  localparam int POS_W = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [POS_W-1:0] load_val,
  input  logic             step,
  input  logic             up,
  output logic [POS_W-1:0] pos
);
  always_ff @(posedge clk) begin
    if (rst)
      pos <= '0;
    else if (load)
      pos <= load_val;
    else if (step)
      pos <= POS_W'(trim_pkg::sat_next(int'(pos), up, TAPS - 1));
  end
endmodule

// File: rtl/trim_tap_decode.sv
module trim_tap_decode #(
  parameter int TAPS  = 32,
  localparam int POS_W = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [POS_W-1:0] pos,
  output logic [TAPS-1:0]  tap
);
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) tap[i] <= (i == 0);
      else     tap[i] <= (pos == POS_W'(i));
    end
  end
endmodule

// File: rtl/trim_store_ctrl.sv
module trim_store_ctrl #(
  parameter int TAPS        = 32,
  parameter int BUSY_CYCLES = 16,
  localparam int POS_W = $clog2(TAPS),
  localparam int CW    = $clog2(BUSY_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             store_req,
  input  logic             sel_lvl,
  input  logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] stored,
  output logic             busy,
  output logic             standby
);
  logic [CW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      stored  <= '0;
      bcnt    <= '0;
      busy    <= 1'b0;
      standby <= 1'b1;
    end else if (store_req) begin
      stored  <= pos;
      bcnt    <= CW'(BUSY_CYCLES);
      busy    <= 1'b1;
      standby <= 1'b0;
    end else if (bcnt != '0) begin
      bcnt    <= bcnt - CW'(1);
      busy    <= (bcnt != CW'(1));
      standby <= (bcnt == CW'(1)) && sel_lvl;
    end else begin
      busy    <= 1'b0;
      standby <= sel_lvl;
    end
  end
endmodule

// File: rtl/trim_wiper.sv
module trim_wiper #(
  parameter int TAPS        = 32,
  parameter int BUSY_CYCLES = 16,
  localparam int POS_W = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_n_in,
  input  logic             step_in,
  input  logic             dir_in,
  input  logic             recall,
  output logic [POS_W-1:0] wiper_pos,
  output logic [POS_W-1:0] stored_pos,
  output logic [TAPS-1:0]  tap_sel,
  output logic             busy,
  output logic             standby
);
  // bit 0 select (idle high), bit 1 step (idle high), bit 2 direction
  localparam logic [2:0] IDLE = 3'b011;

  logic [2:0] lvl, lvl_d;
  logic sel_lvl, step_lvl, dir_lvl;
  logic step_fall, desel_rise, do_step, store_req;

  trim_sync #(.W(3), .IDLE(IDLE)) u_sync (
    .clk(clk), .rst(rst),
    .async_in({dir_in, step_in, sel_n_in}),
    .lvl(lvl), .lvl_d(lvl_d)
  );

  assign sel_lvl    = lvl[0];
  assign step_lvl   = lvl[1];
  assign dir_lvl    = lvl[2];
  assign step_fall  = lvl_d[1] & ~lvl[1];
  assign desel_rise = ~lvl_d[0] & lvl[0];
  assign do_step    = step_fall & ~sel_lvl & ~busy;
  assign store_req  = desel_rise & step_lvl & ~busy;

  trim_counter #(.TAPS(TAPS)) u_cnt (
    .clk(clk), .rst(rst),
    .load(recall), .load_val(stored_pos),
    .step(do_step), .up(dir_lvl),
    .pos(wiper_pos)
  );

  trim_tap_decode #(.TAPS(TAPS)) u_dec (
    .clk(clk), .rst(rst), .pos(wiper_pos), .tap(tap_sel)
  );

  trim_store_ctrl #(.TAPS(TAPS), .BUSY_CYCLES(BUSY_CYCLES)) u_store (
    .clk(clk), .rst(rst),
    .store_req(store_req), .sel_lvl(sel_lvl), .pos(wiper_pos),
    .stored(stored_pos), .busy(busy), .standby(standby)
  );
endmodule

// File: rtl/trim_wiper_chk.sv
module trim_wiper_chk #(
  parameter int TAPS  = 32,
  localparam int POS_W = $clog2(TAPS)
) (
  input logic             clk,
  input logic             rst,
  input logic             recall,
  input logic             sel_lvl,
  input logic [POS_W-1:0] wiper_pos,
  input logic [POS_W-1:0] stored_pos,
  input logic [TAPS-1:0]  tap_sel,
  input logic             busy,
  input logic             standby
);
  AST_ONE_TAP: assert property (@(posedge clk) disable iff (rst)
    $countones(tap_sel) == 1); // R4

  AST_TAP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> tap_sel == ({{(TAPS-1){1'b0}}, 1'b1} << $past(wiper_pos))); // R4

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    !recall |=> ((int'(wiper_pos) - int'($past(wiper_pos)) <= 1) &&
                 (int'($past(wiper_pos)) - int'(wiper_pos) <= 1))); // R3

  AST_STORE_ONLY_AT_START: assert property (@(posedge clk) disable iff (rst)
    !$rose(busy) |-> $stable(stored_pos)); // R5

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (busy && !recall) |=> $stable(wiper_pos)); // R10

  AST_RECALL_LOAD: assert property (@(posedge clk) disable iff (rst)
    recall |=> wiper_pos == $past(stored_pos)); // R7

  AST_STANDBY_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(standby && busy)); // R9

  AST_DESELECT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sel_lvl && !recall) |=> $stable(wiper_pos)); // R1
endmodule

bind trim_wiper trim_wiper_chk #(.TAPS(TAPS)) u_chk (
  .clk(clk), .rst(rst), .recall(recall), .sel_lvl(sel_lvl),
  .wiper_pos(wiper_pos), .stored_pos(stored_pos), .tap_sel(tap_sel),
  .busy(busy), .standby(standby)
);

// File: tb/sim_trim_wiper.sv
`timescale 1ns/1ps
module sim_trim_wiper;
  localparam int TAPS  = 32;
  localparam int BUSY  = 12;
  localparam int POS_W = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, sel_n, step, dir, recall;
  logic [POS_W-1:0] wiper_pos, stored_pos;
  logic [TAPS-1:0]  tap_sel;
  logic busy, standby;

  int checks = 0, fails = 0;
  int exp_pos = 0, exp_store = 0;
  bit done = 1'b0;

  trim_wiper #(.TAPS(TAPS), .BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst(rst), .sel_n_in(sel_n), .step_in(step), .dir_in(dir),
    .recall(recall), .wiper_pos(wiper_pos), .stored_pos(stored_pos),
    .tap_sel(tap_sel), .busy(busy), .standby(standby)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    step = 1'b0; cyc(4);
    step = 1'b1; cyc(4);
  endtask

  task automatic model_step(bit up);
    if (up) exp_pos = (exp_pos >= TAPS - 1) ? TAPS - 1 : exp_pos + 1;
    else    exp_pos = (exp_pos == 0) ? 0 : exp_pos - 1;
  endtask

  task automatic check_pos(string req);
    chk(req, int'(wiper_pos), exp_pos);
    chk(req, int'(tap_sel == (32'd1 << exp_pos)), 1);
  endtask

  initial begin
    rst = 1'b1; sel_n = 1'b1; step = 1'b1; dir = 1'b0; recall = 1'b0;
    cyc(4);
    rst = 1'b0;
    cyc(2);
    // R8 reset state
    chk("R8 wiper", int'(wiper_pos), 0);
    chk("R8 stored", int'(stored_pos), 0);
    chk("R8 tap", int'(tap_sel), 1);
    chk("R8 busy", int'(busy), 0);
    chk("R8 standby", int'(standby), 1);

    // R1: strobes while deselected do nothing
    dir = 1'b1;
    for (int i = 0; i < 3; i++) pulse();
    chk("R1 deselected", int'(wiper_pos), 0);

    sel_n = 1'b0; cyc(4);
    chk("R9 standby when selected", int'(standby), 0);

    // R2/R3 sweep up past the top
    for (int i = 0; i < TAPS + 4; i++) begin
      pulse(); model_step(1'b1);
      check_pos(i < TAPS - 1 ? "R2 up" : "R3 top saturate");
    end
    // sweep down past zero
    dir = 1'b0;
    for (int i = 0; i < TAPS + 4; i++) begin
      pulse(); model_step(1'b0);
      check_pos(i < TAPS - 1 ? "R2 down" : "R3 bottom saturate");
    end

    // R11 latency
    dir = 1'b1;
    for (int i = 0; i < 5; i++) begin pulse(); model_step(1'b1); end
    step = 1'b0;
    cyc(2);
    chk("R11 before third edge", int'(wiper_pos), 5);
    cyc(1);
    chk("R11 at third edge", int'(wiper_pos), 6);
    step = 1'b1; cyc(4);
    exp_pos = 6;
    check_pos("R4 tap");

    // R2 direction changes within one selection
    dir = 1'b0; pulse(); model_step(1'b0);
    check_pos("R2 reverse");
    dir = 1'b1; pulse(); model_step(1'b1); pulse(); model_step(1'b1);
    check_pos("R2 forward again");

    // R5/R9 store with step high
    begin
      int n = 0;
      int both = 0;
      sel_n = 1'b1;
      for (int k = 0; k < 40; k++) begin
        cyc(1);
        if (busy) n++;
        if (busy && standby) both++;
      end
      exp_store = exp_pos;
      chk("R9 busy length", n, BUSY);
      chk("R9 standby excl busy", both, 0);
      chk("R5 stored", int'(stored_pos), exp_store);
      chk("R9 standby after store", int'(standby), 1);
    end

    // R10: selection and step during busy are ignored
    sel_n = 1'b0; cyc(4);
    pulse(); model_step(1'b1);
    check_pos("R2 before second store");
    sel_n = 1'b1; cyc(4);
    exp_store = exp_pos;
    chk("R9 busy raised", int'(busy), 1);
    chk("R5 stored second", int'(stored_pos), exp_store);
    sel_n = 1'b0; cyc(1);
    step = 1'b0; cyc(2);
    step = 1'b1; cyc(20);
    chk("R10 wiper frozen", int'(wiper_pos), exp_pos);
    chk("R10 stored unchanged", int'(stored_pos), exp_store);
    chk("R10 busy over", int'(busy), 0);
    chk("R9 standby selected", int'(standby), 0);
    pulse(); model_step(1'b1);
    check_pos("R10 stepping resumes");

    // R6: release select with step low
    step = 1'b0; cyc(4); model_step(1'b1);
    sel_n = 1'b1; cyc(6);
    step = 1'b1; cyc(4);
    chk("R6 stored kept", int'(stored_pos), exp_store);
    chk("R6 wiper kept", int'(wiper_pos), exp_pos);
    chk("R6 no busy", int'(busy), 0);
    chk("R6 standby", int'(standby), 1);

    // R7 recall
    recall = 1'b1; cyc(1);
    recall = 1'b0;
    exp_pos = exp_store;
    chk("R7 recall", int'(wiper_pos), exp_pos);
    cyc(2);
    check_pos("R4 after recall");

    // R8 reset clears stored value
    rst = 1'b1; cyc(2);
    rst = 1'b0; cyc(2);
    exp_pos = 0; exp_store = 0;
    chk("R8 stored cleared", int'(stored_pos), 0);
    chk("R8 wiper cleared", int'(wiper_pos), 0);
    recall = 1'b1; cyc(1);
    recall = 1'b0; cyc(2);
    check_pos("R7 recall after reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule